// File: doc/BRIEF.md
# Serial ADC readout controller

This block is the host side of a three-wire link to a 12-bit serial converter. It drives a frame-select line and a generated serial clock, and it reads one serial data line. A start request opens a frame by raising the select line. The controller then produces sixteen serial clock periods and captures one bit on every falling clock edge. The first four bits must be zero. The last twelve are the conversion result, most significant bit first. When the frame closes, the result and a framing-error flag are presented together with a single-cycle valid strobe.

After every frame the converter powers itself down. The controller models this by keeping the select line low for a dwell period, followed by a wake-up period. Only after both does it open the next frame. Start requests that arrive during a frame or during either period are remembered and served at the first cycle the timing allows. Every cycle count is derived from the system clock frequency and from nanosecond limits given as parameters. With the defaults (200 MHz system clock, 10 MHz serial clock) the setup delay is 2 cycles, each clock phase is 10 cycles, the dwell is 1480 cycles and the wake-up is 200 cycles.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high, and after it, the block holds select low, serial clock high, valid low, and result and error flag at zero.
- R2: In idle, a start request sampled at a clock edge makes select high after that same edge.
- R3: The first serial clock falling edge follows the select rising edge by SETUP cycles (2 by default, at least 10 ns), and the serial clock is high when select rises.
- R4: A frame has exactly 16 falling edges, and every high and low phase of the serial clock lasts HALF system cycles (10 by default).
- R5: The serial data line is sampled at each falling edge. Bits 5 to 16 of the frame form the result, with bit 5 going to result bit 11.
- R6: One HALF period after the 16th falling edge, the serial clock returns high, select falls and valid pulses for exactly one cycle, all on the same edge. The result is valid in that cycle.
- R7: The error flag (result-side output) is 1 when any of the first four frame bits was 1, and 0 otherwise.
- R8: After a frame, select stays low for DWELL+WAKE+1 cycles at minimum (1681 by default) before it can rise again.
- R9: A start request that arrives during a frame, a dwell or a wake-up period is kept and opens the next frame at the earliest allowed edge.
- R10: Several requests during one busy period produce exactly one extra frame, and the serial clock never toggles while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion |
| sdata_i | input | 1 | Serial data from the converter |
| cs_o | output | 1 | Frame select, high during a frame |
| sclk_o | output | 1 | Serial clock, idle high |
| data_o | output | RES_BITS | Captured result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| ferr_o | output | 1 | Leading-zero violation flag for the result |

## Verification
Take the edge at which a request is accepted as edge 0. Select rises after edge 0. Falling edge k comes at edge SETUP+(k-1)·2·HALF, and the frame closes at edge SETUP+31·HALF, where valid, the result and the error flag appear. The earliest next opening comes DWELL+WAKE+1 edges after the close. The bench has a behavioural model that advances with the same edge count. Its outputs are compared with the design at every falling system clock edge, half a cycle after the registers update. The model's serial-data emulation reacts to the falling serial clock seen by the design, so each captured bit lines up with the edge that samples it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FRAME, SQ_REST} seq_t;
  typedef enum logic [1:0] {PT_OFF, PT_DWELL, PT_WAKE} pt_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_edgegen.sv
module adc_rd_edgegen
  import adc_rd_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HALF_CYC  = 10,
  parameter int NFALL     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  output logic sclk_o,
  output logic fall_o,
  output logic close_o
);
  localparam int CW = $clog2(imax(SETUP_CYC, HALF_CYC) + 1);
  localparam int NW = $clog2(NFALL + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HALF_LAST  = CW'(HALF_CYC - 1);
  localparam logic [NW-1:0] NFALL_V    = NW'(NFALL);

  logic [CW-1:0] cnt_q;
  logic [NW-1:0] nfall_q;
  logic          sclk_q, run_q, setup_q;
  logic          tick;

  always_comb begin
    tick    = run_q && (setup_q ? (cnt_q == SETUP_LAST) : (cnt_q == HALF_LAST));
    fall_o  = tick && (setup_q || sclk_q);
    close_o = tick && !setup_q && !sclk_q && (nfall_q == NFALL_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      nfall_q <= '0;
      sclk_q  <= 1'b1;
      run_q   <= 1'b0;
      setup_q <= 1'b0;
    end else if (open_i) begin
      cnt_q   <= '0;
      nfall_q <= '0;
      sclk_q  <= 1'b1;
      run_q   <= 1'b1;
      setup_q <= 1'b1;
    end else if (run_q) begin
      if (tick) begin
        cnt_q   <= '0;
        setup_q <= 1'b0;
        if (fall_o) begin
          sclk_q  <= 1'b0;
          nfall_q <= nfall_q + 1'b1;
        end else begin
          sclk_q <= 1'b1;
        end
        if (close_o) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;

  // R4: outside the setup delay, the falling-edge count stays between 1 and NFALL
  assert_shift_counted_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && !setup_q) |-> (nfall_q >= NW'(1) && nfall_q <= NFALL_V));

  // R10: with the frame not running, the serial clock is high
  assert_stopped_high_R10: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> sclk_q);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int RES_BITS  = 12,
  parameter int LEAD_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_i,
  input  logic                bit_i,
  input  logic                load_i,
  output logic [RES_BITS-1:0] data_o,
  output logic                ferr_o,
  output logic                valid_o
);
  localparam int FRAME_BITS = RES_BITS + LEAD_BITS;

  logic [FRAME_BITS-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[FRAME_BITS-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      ferr_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        data_o <= sr_q[RES_BITS-1:0];
        ferr_o <= |sr_q[FRAME_BITS-1:RES_BITS];
      end
    end
  end

  // R6: a result is never loaded in the same cycle as a shift
  assert_load_not_shift_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !shift_i);

endmodule

// File: rtl/adc_rd_pwrtimer.sv
module adc_rd_pwrtimer
  import adc_rd_pkg::*;
#(
  parameter int DWELL_CYC = 1480,
  parameter int WAKE_CYC  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(imax(DWELL_CYC, WAKE_CYC) + 1);
  localparam logic [CW-1:0] DWELL_LAST = CW'(DWELL_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);

  pt_t           ph_q;
  logic [CW-1:0] cnt_q;

  assign done_o = (ph_q == PT_WAKE) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PT_OFF;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PT_OFF: begin
          if (start_i) begin
            ph_q  <= PT_DWELL;
            cnt_q <= DWELL_LAST;
          end
        end
        PT_DWELL: begin
          if (cnt_q == '0) begin
            ph_q  <= PT_WAKE;
            cnt_q <= WAKE_LAST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PT_WAKE: begin
          if (cnt_q == '0) ph_q <= PT_OFF;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PT_OFF;
      endcase
    end
  end

  // R8: the sequencer never restarts the timer while it is still counting
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (ph_q == PT_OFF));

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int SCLK_KHZ  = 10000,
  parameter int SETUP_NS  = 10,
  parameter int DWELL_NS  = 7400,
  parameter int WAKE_NS   = 1000,
  parameter int RES_BITS  = 12,
  parameter int LEAD_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                sdata_i,
  output logic                cs_o,
  output logic                sclk_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                ferr_o
);
  localparam int SETUP_CYC  = imax(1, cdiv(SETUP_NS * CLK_MHZ, 1000));
  localparam int HALF_CYC   = imax(1, cdiv(CLK_MHZ * 1000, 2 * SCLK_KHZ));
  localparam int DWELL_CYC  = imax(1, cdiv(DWELL_NS * CLK_MHZ, 1000));
  localparam int WAKE_CYC   = imax(1, cdiv(WAKE_NS * CLK_MHZ, 1000));
  localparam int FRAME_BITS = RES_BITS + LEAD_BITS;
  localparam int REST_MIN   = DWELL_CYC + WAKE_CYC + 1;

  seq_t st_q;
  logic cs_q, pend_q;
  logic open_w, fall_w, close_w, done_w;

  assign open_w = (st_q == SQ_IDLE) && (start_i || pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_IDLE;
      cs_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE:  if (open_w) begin st_q <= SQ_FRAME; cs_q <= 1'b1; end
        SQ_FRAME: if (close_w) begin st_q <= SQ_REST; cs_q <= 1'b0; end
        SQ_REST:  if (done_w) st_q <= SQ_IDLE;
        default:  st_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else if (open_w) pend_q <= 1'b0;
    else pend_q <= pend_q | start_i;
  end

  adc_rd_edgegen #(
    .SETUP_CYC(SETUP_CYC), .HALF_CYC(HALF_CYC), .NFALL(FRAME_BITS)
  ) u_edge (
    .clk(clk), .rst(rst), .open_i(open_w),
    .sclk_o(sclk_o), .fall_o(fall_w), .close_o(close_w)
  );

  adc_rd_shifter #(
    .RES_BITS(RES_BITS), .LEAD_BITS(LEAD_BITS)
  ) u_shift (
    .clk(clk), .rst(rst), .shift_i(fall_w), .bit_i(sdata_i), .load_i(close_w),
    .data_o(data_o), .ferr_o(ferr_o), .valid_o(valid_o)
  );

  adc_rd_pwrtimer #(
    .DWELL_CYC(DWELL_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_pwr (
    .clk(clk), .rst(rst), .start_i(close_w), .done_o(done_w)
  );

  assign cs_o = cs_q;

  // checker state for the assertions below
  logic        sclk_d, had_frame;
  int unsigned falls_seen, low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b1;
      had_frame  <= 1'b0;
      falls_seen <= 0;
      low_run    <= 0;
    end else begin
      sclk_d <= sclk_o;
      if (valid_o) had_frame <= 1'b1;
      if (!cs_o) falls_seen <= 0;
      else if (sclk_d && !sclk_o) falls_seen <= falls_seen + 1;
      if (cs_o) low_run <= 0;
      else if (low_run < 32'h7fff_ffff) low_run <= low_run + 1;
    end
  end

  assert_cs_rise_sclk_high_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_o) |-> sclk_o);

  assert_idle_sclk_high_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_o |-> sclk_o);

  assert_valid_at_close_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $fell(cs_o));

  assert_sixteen_falls_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (falls_seen == FRAME_BITS));

  assert_rest_gap_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_o) && had_frame) |-> (low_run >= REST_MIN));

  assert_pending_served_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && st_q == SQ_IDLE) |=> cs_o);

endmodule

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  localparam int SETUP = 2;
  localparam int H     = 10;
  localparam int PD    = 1480;
  localparam int PU    = 200;

  logic clk = 1'b0;
  logic rst, start_i, sdata_i;
  logic cs_o, sclk_o, valid_o, ferr_o;
  logic [11:0] data_o;

  always #2.5 clk = ~clk;

  adc_rd_ctrl u_adc_rd_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .sdata_i(sdata_i),
    .cs_o(cs_o), .sclk_o(sclk_o), .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter emulation: a new bit after each falling serial clock edge
  int fidx = 0;
  int bitn = 0;
  logic [15:0] word = '0;
  logic cs_prev = 1'b0, sclk_prev = 1'b1;

  function automatic logic [15:0] mkword(input int n);
    logic [3:0] lead;
    lead = (n % 3 == 1) ? 4'((n % 15) + 1) : 4'h0;
    return {lead, 12'(n * 12'h9D5) ^ 12'hA5C};
  endfunction

  always @(negedge clk) begin
    if (cs_o && !cs_prev) begin
      fidx++;
      word = mkword(fidx);
      bitn = 0;
    end else if (!sclk_o && sclk_prev) begin
      bitn++;
    end
    sdata_i = (cs_o && bitn < 16) ? word[15-bitn] : 1'b1;
    cs_prev = cs_o;
    sclk_prev = sclk_o;
  end

  // behavioural reference model
  int age = -1, cool = 0, rel;
  bit pend = 0, opened;
  logic exp_cs = 0, exp_sclk = 1, exp_valid = 0, exp_ferr = 0;
  logic [11:0] exp_data = '0;
  logic [15:0] cap = '0;
  int exp_frames = 0, dut_frames = 0;

  always @(posedge clk) begin
    if (rst) begin
      age = -1; cool = 0; pend = 0;
      exp_cs = 0; exp_sclk = 1; exp_valid = 0; exp_data = '0; exp_ferr = 0;
    end else begin
      exp_valid = 0;
      opened = 0;
      if (age >= 0) begin
        age++;
        rel = age - SETUP;
        if (rel >= 0 && rel % (2*H) == 0 && rel / (2*H) < 16) begin
          exp_sclk = 0;
          cap = {cap[14:0], sdata_i};
        end else if (rel >= 0 && rel % (2*H) == H) begin
          exp_sclk = 1;
          if (rel / (2*H) == 15) begin
            exp_cs = 0; exp_valid = 1;
            exp_data = cap[11:0]; exp_ferr = |cap[15:12];
            age = -1; cool = PD + PU;
            exp_frames++;
          end
        end
      end else if (cool > 0) begin
        cool--;
      end else if (start_i || pend) begin
        age = 0; exp_cs = 1; pend = 0; opened = 1;
      end
      if (start_i && !opened) pend = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cs_o === exp_cs, "R2 R8 R9 cs", cs_o, exp_cs);
      chk(sclk_o === exp_sclk, "R3 R4 R10 sclk", sclk_o, exp_sclk);
      chk(valid_o === exp_valid, "R6 valid", valid_o, exp_valid);
      if (valid_o) dut_frames++;
      if (exp_valid) begin
        chk(data_o === exp_data, "R5 data", data_o, exp_data);
        chk(ferr_o === exp_ferr, "R7 ferr", ferr_o, exp_ferr);
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; sdata_i = 1'b1;
    wait_cyc(4);
    // R1: reset state
    chk(cs_o === 1'b0, "R1 cs", cs_o, 0);
    chk(sclk_o === 1'b1, "R1 sclk", sclk_o, 1);
    chk(valid_o === 1'b0, "R1 valid", valid_o, 0);
    chk(data_o === 12'h0, "R1 data", data_o, 0);
    chk(ferr_o === 1'b0, "R1 ferr", ferr_o, 0);
    rst = 1'b0;
    cmp_on = 1;
    pulse(); wait_cyc(2100);
    // R9: request during a frame
    pulse(); wait_cyc(50); pulse(); wait_cyc(4200);
    // R10: several requests during one rest period
    pulse(); wait_cyc(500); pulse(); wait_cyc(300); pulse(); wait_cyc(300); pulse();
    wait_cyc(4300);
    // back-to-back frames with start held high
    @(negedge clk); start_i = 1'b1; wait_cyc(7000); start_i = 1'b0;
    wait_cyc(2100);
    // reset in the middle of a frame
    pulse(); wait_cyc(100);
    rst = 1'b1; wait_cyc(3);
    chk(cs_o === 1'b0 && sclk_o === 1'b1, "R1 mid-frame reset", {cs_o, sclk_o}, 2'b01);
    rst = 1'b0;
    wait_cyc(50); pulse(); wait_cyc(2100);
    chk(dut_frames == exp_frames, "R9 R10 frame count", dut_frames, exp_frames);
    chk(exp_frames >= 10, "R9 frames served", exp_frames, 10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule